// File: doc/BRIEF.md
# Super-Pixel Hit Packet Builder

This block serves one cluster of eight binary pixels laid out as two columns by four rows with fixed edges. In every clock period it samples the eight hit strobes. If any strobe is high, it builds one packet that holds the cluster's fixed address, the bunch timestamp present in that same period, and an 8-bit map showing which pixels fired. Address and timestamp are therefore sent once for the whole group instead of once per pixel.

Finished packets go into one of two buffers shared by all eight pixels. A packet is offered on a valid/ready output as soon as it is formed, and buffers drain oldest first. When both buffers hold packets and none leaves in that cycle, the new hits are lost and a saturating overflow counter records the loss.

Top module: `spx_packet_builder`

## Requirements
- R1: After reset, `pkt_valid_o` is 0 and `ovf_count_o` is 0.
- R2: A cycle with at least one strobe high in `hit_i` creates exactly one packet, and bit i of its hit map equals strobe i. A cycle with all strobes low creates no packet.
- R3: The 30-bit packet holds the `CLUSTER_ADDR` parameter in bits [29:17], the value of `ts_i` from the hit cycle in bits [16:8], and the hit map in bits [7:0].
- R4: A packet accepted into an empty block shows on `pkt_data_o`, with `pkt_valid_o` high, right after the clock edge that sampled its hits.
- R5: Packets leave in the order they were formed. A transfer happens on a clock edge where `pkt_valid_o` and `pkt_ready_i` are both 1.
- R6: While `pkt_valid_o` is 1 and `pkt_ready_i` is 0, `pkt_valid_o` stays 1 and `pkt_data_o` stays unchanged.
- R7: If both buffers are occupied and no transfer happens in a cycle with hits, those hits are dropped, the stored packets are unchanged, and `ovf_count_o` rises by one. In every other cycle the counter holds its value.
- R8: If both buffers are occupied and a transfer happens in the same cycle as new hits, the departing packet frees a buffer, the new packet is stored, and nothing is counted as dropped.
- R9: `ovf_count_o` saturates at its largest value (255 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; hits are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 8 | Binary hit strobe per pixel of the cluster |
| ts_i | input | 9 | Current bunch timestamp |
| pkt_ready_i | input | 1 | Downstream accepts the offered packet |
| pkt_valid_o | output | 1 | A packet is offered |
| pkt_data_o | output | 30 | Offered packet: address, timestamp, hit map |
| ovf_count_o | output | 8 | Saturating count of cycles whose hits were dropped |

## Verification
Capture of new hits and departure of a stored packet can happen on the same edge. This matters most when both buffers are full, because whether the hits survive depends on that departure. The bench fills both buffers while holding ready low, then raises ready in the same cycle as a new hit pattern. It judges the result by the drained order of the three packets and by the overflow count staying the same. A second run holds ready low for the hit cycle, and there the drop must show up as a count step with the packet sequence unchanged.

// File: rtl/spx_packet_builder.sv
`timescale 1ns/1ps
module spx_packet_builder #(
  parameter int NPIX   = 8,
  parameter int TS_W   = 9,
  parameter int ADDR_W = 13,
  parameter int OVF_W  = 8,
  parameter logic [ADDR_W-1:0] CLUSTER_ADDR = 13'h0A5,
  localparam int PKT_W = ADDR_W + TS_W + NPIX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIX-1:0]   hit_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              pkt_ready_i,
  output logic              pkt_valid_o,
  output logic [PKT_W-1:0]  pkt_data_o,
  output logic [OVF_W-1:0]  ovf_count_o
);
  logic [PKT_W-1:0] slot_q [2];
  logic             wr_q, rd_q;
  logic [1:0]       fill_q;

  wire any_hit = |hit_i;
  wire full    = (fill_q == 2'd2);
  wire pop     = pkt_valid_o & pkt_ready_i;
  wire push    = any_hit & (~full | pop);
  wire drop    = any_hit & full & ~pop;

  assign pkt_valid_o = (fill_q != 2'd0);
  assign pkt_data_o  = slot_q[rd_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= {CLUSTER_ADDR, ts_i, hit_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q        <= 1'b0;
      rd_q        <= 1'b0;
      fill_q      <= 2'd0;
      ovf_count_o <= '0;
    end else begin
      if (push) wr_q <= ~wr_q;
      if (pop)  rd_q <= ~rd_q;
      fill_q <= fill_q + 2'(push) - 2'(pop);
      if (drop && ovf_count_o != {OVF_W{1'b1}}) ovf_count_o <= ovf_count_o + 1'b1;
    end
  end
endmodule

// File: rtl/spx_packet_builder_chk.sv
`timescale 1ns/1ps
module spx_packet_builder_chk #(
  parameter int NPIX  = 8,
  parameter int PKT_W = 30,
  parameter int OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPIX-1:0]  hit_i,
  input logic             pkt_ready_i,
  input logic             pkt_valid_o,
  input logic [PKT_W-1:0] pkt_data_o,
  input logic [OVF_W-1:0] ovf_count_o,
  input logic [1:0]       fill_q
);
  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (!pkt_valid_o && ovf_count_o == '0)); // R1
  AST_HIT_OFFERED: assert property (@(posedge clk) disable iff (!rst_n) (|hit_i) |=> pkt_valid_o); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n) (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o))); // R6
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n) (fill_q == 2'd2 && !pkt_ready_i && (|hit_i) && ovf_count_o != OVF_MAX) |=> (ovf_count_o == $past(ovf_count_o) + 1'b1)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !(fill_q == 2'd2 && !pkt_ready_i && (|hit_i)) |=> $stable(ovf_count_o)); // R7
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n) (fill_q == 2'd2 && pkt_ready_i && (|hit_i)) |=> (fill_q == 2'd2)); // R8
  AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (ovf_count_o == OVF_MAX) |=> (ovf_count_o == OVF_MAX)); // R9
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (fill_q <= 2'd2)); // R5
endmodule

bind spx_packet_builder spx_packet_builder_chk #(
  .NPIX(NPIX), .PKT_W(PKT_W), .OVF_W(OVF_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .pkt_ready_i(pkt_ready_i),
  .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o),
  .ovf_count_o(ovf_count_o), .fill_q(fill_q)
);

// File: tb/spx_packet_builder_tb_top.sv
`timescale 1ns/1ps
module spx_packet_builder_tb_top;
  localparam logic [12:0] ADDR = 13'h12B7;
  localparam int NVEC = 10;
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h01, 9'h000}, {8'h80, 9'h1FF}, {8'h00, 9'h055}, {8'hFF, 9'h123},
    {8'h5A, 9'h0AA}, {8'h00, 9'h000}, {8'h24, 9'h100}, {8'hC3, 9'h001},
    {8'h10, 9'h0F0}, {8'h00, 9'h1AB}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hit = '0;
  logic [8:0]  ts = '0;
  logic        rdy = 1'b0;
  logic        vld;
  logic [29:0] dat;
  logic [7:0]  ovf;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  spx_packet_builder #(.CLUSTER_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .ts_i(ts), .pkt_ready_i(rdy),
    .pkt_valid_o(vld), .pkt_data_o(dat), .ovf_count_o(ovf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(logic [7:0] h, logic [8:0] t, logic r);
    hit = h; ts = t; rdy = r;
    @(negedge clk);
  endtask

  function automatic logic [29:0] pk(logic [7:0] h, logic [8:0] t);
    return {ADDR, t, h};
  endfunction

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 valid after reset", {31'd0, vld}, 32'd0);
    check("R1 ovf after reset", {24'd0, ovf}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      tick(VEC[i][16:9], VEC[i][8:0], 1'b1);
      check("R2/R4 valid", {31'd0, vld}, {31'd0, |VEC[i][16:9]});
      if (|VEC[i][16:9]) check("R3 layout", {2'b0, dat}, {2'b0, pk(VEC[i][16:9], VEC[i][8:0])});
    end
    tick(8'h00, 9'h0, 1'b1);
    check("R2 empty after drain", {31'd0, vld}, 32'd0);

    tick(8'h11, 9'h011, 1'b0);
    check("R4 first packet", {2'b0, dat}, {2'b0, pk(8'h11, 9'h011)});
    tick(8'h22, 9'h022, 1'b0);
    check("R6 hold while second stored", {2'b0, dat}, {2'b0, pk(8'h11, 9'h011)});
    tick(8'h00, 9'h0, 1'b0);
    check("R6 hold valid", {31'd0, vld}, 32'd1);
    tick(8'h33, 9'h033, 1'b0);
    check("R7 drop counted", {24'd0, ovf}, 32'd1);
    check("R7 head unchanged", {2'b0, dat}, {2'b0, pk(8'h11, 9'h011)});
    tick(8'h00, 9'h0, 1'b1);
    check("R5 second in order", {2'b0, dat}, {2'b0, pk(8'h22, 9'h022)});
    tick(8'h44, 9'h044, 1'b0);
    check("R5 head still second", {2'b0, dat}, {2'b0, pk(8'h22, 9'h022)});
    tick(8'h55, 9'h055, 1'b1);
    check("R8 no drop on swap", {24'd0, ovf}, 32'd1);
    check("R8 next packet", {2'b0, dat}, {2'b0, pk(8'h44, 9'h044)});
    tick(8'h00, 9'h0, 1'b1);
    check("R8 swapped-in packet kept", {2'b0, dat}, {2'b0, pk(8'h55, 9'h055)});
    tick(8'h00, 9'h0, 1'b1);
    check("R5 drained", {31'd0, vld}, 32'd0);

    tick(8'h01, 9'h101, 1'b0);
    tick(8'h02, 9'h102, 1'b0);
    for (int k = 0; k < 300; k++) tick(8'hFF, 9'(k), 1'b0);
    check("R9 saturated", {24'd0, ovf}, 32'd255);
    check("R7 head survives drops", {2'b0, dat}, {2'b0, pk(8'h01, 9'h101)});

    rst_n = 1'b0;
    tick(8'h00, 9'h0, 1'b0);
    rst_n = 1'b1;
    check("R1 valid after re-reset", {31'd0, vld}, 32'd0);
    check("R1 ovf after re-reset", {24'd0, ovf}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule